// File: doc/BRIEF.md
# Parallel ADC conversion-and-read sequencer

This block is the host-side controller for a sampling converter with a 14-bit parallel data bus. On request it drives an active-low conversion-start strobe. It then watches the converter's busy flag through a synchronizer, waiting first for busy to rise and then for it to fall. Next it lowers chip select and the read strobe together, latches the parallel word, and hands the word to the system as a single-cycle valid pulse. After the read it leaves time for the bus to release and for the converter to reacquire before it will issue another start.

Every analog timing bound is given as a parameter in nanoseconds. Each one is rounded up to whole cycles of a clock whose period is also a parameter. Two timeouts watch the converter: one for a busy flag that never rises, and one for a conversion that never ends. A standby request blocks starts while it is held and for a wake-up interval after it is dropped. The host can trigger one conversion with `go_i`, or hold `cont_i` to run conversions back to back.

Top module: `adc_rdseq`

## Requirements
- R1: After reset `cnv_n_o`, `cs_n_o`, `rd_n_o` and `sleep_n_o` are high and `vld_o`, `err_nobusy_o`, `err_conv_o` are low.
- R2: A start is taken only while idle with `go_i` or `cont_i` high; `cnv_n_o` then stays low for exactly ceil(START_NS/period) cycles (5 at defaults) before returning high.
- R3: If busy is not seen within ceil(BUSY_RISE_NS/period)+SYNC_STAGES cycles after `cnv_n_o` rises (11 at defaults), `err_nobusy_o` pulses for one cycle exactly that many cycles after the rise, and no read is performed.
- R4: If busy stays high, `err_conv_o` pulses for one cycle between ceil((CONV_NS+CONV_MARGIN_NS)/period)+SYNC_STAGES and that bound plus SYNC_STAGES+2 cycles after busy rose (302 to 306 at defaults), and no read is performed.
- R5: `rd_n_o` falls only after busy has fallen; it stays low for at least ceil(max(RD_PULSE_NS,RD_ACCESS_NS)/period) cycles (5 at defaults); `cs_n_o` is low in every cycle where `rd_n_o` is low.
- R6: `dat_o` carries the value of `data_i` at the clock edge where `rd_n_o` returns high, and `vld_o` is high for exactly that one following cycle.
- R7: The next falling edge of `cnv_n_o` comes at least ceil(RELEASE_NS/period)+ceil(ACQ_NS/period) cycles after `rd_n_o` rises (42 at defaults).
- R8: `sleep_n_o` follows the inverse of `stby_i` one cycle later. No start is issued while `stby_i` is high, even when `go_i` rises in the same cycle. No start is issued earlier than ceil(WAKE_NS/period) cycles (250 at defaults) after `stby_i` falls.
- R9: A `go_i` pulse that arrives while a conversion is in progress is ignored: it produces no further start strobe.
- R10: With `cont_i` held high, conversions repeat without further requests, and each one delivers its own word with a valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go_i | input | 1 | Request one conversion (level, sampled while idle) |
| cont_i | input | 1 | Continuous conversion enable |
| stby_i | input | 1 | Standby request, active high |
| busy_i | input | 1 | Converter busy flag (asynchronous) |
| data_i | input | DATA_W | Converter parallel data bus |
| cnv_n_o | output | 1 | Conversion-start strobe, active low |
| cs_n_o | output | 1 | Chip select, active low |
| rd_n_o | output | 1 | Read strobe, active low |
| sleep_n_o | output | 1 | Standby control to converter, low while asleep |
| vld_o | output | 1 | One-cycle valid for `dat_o` |
| dat_o | output | DATA_W | Captured conversion word |
| err_nobusy_o | output | 1 | One-cycle pulse: busy never rose |
| err_conv_o | output | 1 | One-cycle pulse: busy never fell |

## Verification
A standby request and a start request can arrive in the same clock cycle. The bench provokes this by raising `stby_i` and `go_i` on the same falling clock edge. It then checks that no start strobe appears while standby is held, that `sleep_n_o` drops, and that the eventual start comes no sooner than the wake-up interval after release. A start request can also coincide with a conversion already running. For that case, `go_i` is pulsed while busy is high, and the count of start strobes must stay at one.

// File: rtl/adc_rdseq_pkg.sv
package adc_rdseq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_START = 3'd1,
      ST_WHI   = 3'd2,
      ST_WLO   = 3'd3,
      ST_READ  = 3'd4,
      ST_REL   = 3'd5,
      ST_ACQ   = 3'd6
   } seq_st_e;

   // ceiling of a nanosecond bound over the clock period, never below one cycle
   function automatic int ns_to_cyc(input int ns, input int period_ps);
      int c;
      c = (ns * 1000 + period_ps - 1) / period_ps;
      if (c < 1) c = 1;
      return c;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/adc_rdseq_sync.sv
module adc_rdseq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   logic [STAGES-1:0] sh_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q[0] <= 1'b0;
            else        sh_q[0] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q[i] <= 1'b0;
            else        sh_q[i] <= sh_q[i-1];
         end
      end
   end

   assign q_o = sh_q[STAGES-1];

endmodule

// File: rtl/adc_rdseq_wake.sv
module adc_rdseq_wake #(
   parameter int N_WAKE = 250,
   parameter int CW     = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic stby_i,
   output logic ok_o
);

   localparam logic [CW-1:0] L_WAKE = CW'(N_WAKE);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (stby_i)       cnt_q <= L_WAKE;
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign ok_o = (cnt_q == '0);

   // R8: a sampled standby request always closes the gate
   a_r8_wake_block: assert property (@(posedge clk) disable iff (!rst_n)
      stby_i |=> !ok_o);

endmodule

// File: rtl/adc_rdseq_fsm.sv
module adc_rdseq_fsm
   import adc_rdseq_pkg::*;
#(
   parameter int DATA_W  = 14,
   parameter int SYNC_N  = 2,
   parameter int N_START = 5,
   parameter int N_BHI   = 9,
   parameter int N_CONV  = 300,
   parameter int N_RD    = 5,
   parameter int N_REL   = 4,
   parameter int N_ACQ   = 38,
   parameter int CW      = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go_i,
   input  logic              cont_i,
   input  logic              stby_i,
   input  logic              wake_ok_i,
   input  logic              busy_s_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              cnv_n_o,
   output logic              cs_n_o,
   output logic              rd_n_o,
   output logic              vld_o,
   output logic [DATA_W-1:0] dat_o,
   output logic              err_nobusy_o,
   output logic              err_conv_o
);

   localparam logic [CW-1:0] L_START = CW'(N_START - 1);
   localparam logic [CW-1:0] L_BHI   = CW'(N_BHI + SYNC_N - 1);
   localparam logic [CW-1:0] L_CONV  = CW'(N_CONV + SYNC_N - 1);
   localparam logic [CW-1:0] L_RD    = CW'(N_RD - 1);
   localparam logic [CW-1:0] L_REL   = CW'(N_REL - 1);
   localparam logic [CW-1:0] L_ACQ   = CW'(N_ACQ - 1);

   seq_st_e           st_q, st_d;
   logic [CW-1:0]     cnt_q, cnt_d;
   logic              busy_prev_q;
   logic              cap, e_nb, e_cv;
   logic              cnv_n_q, cs_n_q, rd_n_q, vld_q, enb_q, ecv_q;
   logic [DATA_W-1:0] dat_q;
   logic              cnt_zero;

   assign cnt_zero = (cnt_q == '0);

   always_comb begin
      st_d  = st_q;
      cnt_d = cnt_zero ? cnt_q : cnt_q - 1'b1;
      cap   = 1'b0;
      e_nb  = 1'b0;
      e_cv  = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if ((go_i || cont_i) && wake_ok_i && !stby_i) begin
               st_d  = ST_START;
               cnt_d = L_START;
            end
         end
         ST_START: begin
            if (cnt_zero) begin
               st_d  = ST_WHI;
               cnt_d = L_BHI;
            end
         end
         ST_WHI: begin
            if (busy_s_i) begin
               st_d  = ST_WLO;
               cnt_d = L_CONV;
            end else if (cnt_zero) begin
               e_nb  = 1'b1;
               st_d  = ST_ACQ;
               cnt_d = L_ACQ;
            end
         end
         ST_WLO: begin
            if (busy_prev_q && !busy_s_i) begin
               st_d  = ST_READ;
               cnt_d = L_RD;
            end else if (cnt_zero) begin
               e_cv  = 1'b1;
               st_d  = ST_ACQ;
               cnt_d = L_ACQ;
            end
         end
         ST_READ: begin
            if (cnt_zero) begin
               cap   = 1'b1;
               st_d  = ST_REL;
               cnt_d = L_REL;
            end
         end
         ST_REL: begin
            if (cnt_zero) begin
               st_d  = ST_ACQ;
               cnt_d = L_ACQ;
            end
         end
         ST_ACQ: begin
            if (cnt_zero) st_d = ST_IDLE;
         end
         default: begin
            st_d  = ST_IDLE;
            cnt_d = '0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= ST_IDLE;
         cnt_q       <= '0;
         busy_prev_q <= 1'b0;
         cnv_n_q     <= 1'b1;
         cs_n_q      <= 1'b1;
         rd_n_q      <= 1'b1;
         vld_q       <= 1'b0;
         enb_q       <= 1'b0;
         ecv_q       <= 1'b0;
         dat_q       <= '0;
      end else begin
         st_q        <= st_d;
         cnt_q       <= cnt_d;
         busy_prev_q <= busy_s_i;
         cnv_n_q     <= (st_d != ST_START);
         cs_n_q      <= (st_d != ST_READ);
         rd_n_q      <= (st_d != ST_READ);
         vld_q       <= cap;
         enb_q       <= e_nb;
         ecv_q       <= e_cv;
         if (cap) dat_q <= data_i;
      end
   end

   assign cnv_n_o      = cnv_n_q;
   assign cs_n_o       = cs_n_q;
   assign rd_n_o       = rd_n_q;
   assign vld_o        = vld_q;
   assign dat_o        = dat_q;
   assign err_nobusy_o = enb_q;
   assign err_conv_o   = ecv_q;

   // checker-side count of low strobe cycles
   logic [CW-1:0] lo_len_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        lo_len_q <= '0;
      else if (!cnv_n_q) lo_len_q <= lo_len_q + 1'b1;
      else               lo_len_q <= '0;
   end

   // R2: start strobe honours its minimum low width
   a_r2_cnv_width: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cnv_n_o) |-> (lo_len_q >= CW'(N_START)));

   // R5: chip select covers every read-strobe cycle
   a_r5_cs_covers_rd: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n_o |-> !cs_n_o);

   // R5: read strobe opens only once synchronized busy is low
   a_r5_rd_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rd_n_o) |-> $past(!busy_s_i));

   // R8: no start strobe while asleep or waking
   a_r8_no_start_asleep: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cnv_n_o) |-> $past(wake_ok_i && !stby_i));

   // R6: valid is a single-cycle pulse
   a_r6_vld_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      vld_o |=> !vld_o);

   // R3, R4: a conversion ends in a word or in exactly one error kind
   a_r3_r4_outcome_excl: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({vld_o, err_nobusy_o, err_conv_o}));

endmodule

// File: rtl/adc_rdseq.sv
module adc_rdseq
   import adc_rdseq_pkg::*;
#(
   parameter int DATA_W         = 14,
   parameter int CLK_PS         = 8000,
   parameter int SYNC_STAGES    = 2,
   parameter int START_NS       = 35,
   parameter int BUSY_RISE_NS   = 70,
   parameter int CONV_NS        = 2200,
   parameter int CONV_MARGIN_NS = 200,
   parameter int RD_PULSE_NS    = 35,
   parameter int RD_ACCESS_NS   = 40,
   parameter int RELEASE_NS     = 30,
   parameter int WAKE_NS        = 2000,
   parameter int ACQ_NS         = 300
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go_i,
   input  logic              cont_i,
   input  logic              stby_i,
   input  logic              busy_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              cnv_n_o,
   output logic              cs_n_o,
   output logic              rd_n_o,
   output logic              sleep_n_o,
   output logic              vld_o,
   output logic [DATA_W-1:0] dat_o,
   output logic              err_nobusy_o,
   output logic              err_conv_o
);

   localparam int N_START = ns_to_cyc(START_NS, CLK_PS);
   localparam int N_BHI   = ns_to_cyc(BUSY_RISE_NS, CLK_PS);
   localparam int N_CONV  = ns_to_cyc(CONV_NS + CONV_MARGIN_NS, CLK_PS);
   localparam int N_RD    = ns_to_cyc(imax(RD_PULSE_NS, RD_ACCESS_NS), CLK_PS);
   localparam int N_REL   = ns_to_cyc(RELEASE_NS, CLK_PS);
   localparam int N_ACQ   = ns_to_cyc(ACQ_NS, CLK_PS);
   localparam int N_WAKE  = ns_to_cyc(WAKE_NS, CLK_PS);
   localparam int N_MAX   = imax(imax(imax(N_START, N_BHI), imax(N_CONV, N_RD)),
                                 imax(imax(N_REL, N_ACQ), N_WAKE)) + SYNC_STAGES;
   localparam int CW      = $clog2(N_MAX + 1) + 1;

   if (DATA_W < 1) begin : g_bad_width
      $error("adc_rdseq: DATA_W must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("adc_rdseq: SYNC_STAGES must be at least 2");
   end
   if (CLK_PS < 1) begin : g_bad_clk
      $error("adc_rdseq: CLK_PS must be positive");
   end

   logic busy_s;
   logic wake_ok;
   logic sleep_n_q;

   adc_rdseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (busy_i),
      .q_o   (busy_s)
   );

   adc_rdseq_wake #(.N_WAKE(N_WAKE), .CW(CW)) u_wake (
      .clk    (clk),
      .rst_n  (rst_n),
      .stby_i (stby_i),
      .ok_o   (wake_ok)
   );

   adc_rdseq_fsm #(
      .DATA_W  (DATA_W),
      .SYNC_N  (SYNC_STAGES),
      .N_START (N_START),
      .N_BHI   (N_BHI),
      .N_CONV  (N_CONV),
      .N_RD    (N_RD),
      .N_REL   (N_REL),
      .N_ACQ   (N_ACQ),
      .CW      (CW)
   ) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .go_i         (go_i),
      .cont_i       (cont_i),
      .stby_i       (stby_i),
      .wake_ok_i    (wake_ok),
      .busy_s_i     (busy_s),
      .data_i       (data_i),
      .cnv_n_o      (cnv_n_o),
      .cs_n_o       (cs_n_o),
      .rd_n_o       (rd_n_o),
      .vld_o        (vld_o),
      .dat_o        (dat_o),
      .err_nobusy_o (err_nobusy_o),
      .err_conv_o   (err_conv_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sleep_n_q <= 1'b1;
      else        sleep_n_q <= !stby_i;
   end
   assign sleep_n_o = sleep_n_q;

   // R8: sleep control tracks the standby request one cycle late
   a_r8_sleep_follow: assert property (@(posedge clk) disable iff (!rst_n)
      stby_i |=> !sleep_n_o);

endmodule

// File: tb/adc_rdseq_test.sv
module adc_rdseq_test;

   localparam int PS = 8000;
   function automatic int cyc_of(input int ns);
      return (ns * 1000 + PS - 1) / PS;
   endfunction
   localparam int E_START = cyc_of(35);
   localparam int E_BHI   = cyc_of(70) + 2;
   localparam int E_CONV  = cyc_of(2400) + 2;
   localparam int E_RD    = cyc_of(40);
   localparam int E_GAP   = cyc_of(30) + cyc_of(300);
   localparam int E_WAKE  = cyc_of(2000);
   localparam int BUSY_DLY = 3;
   localparam int CONV_CYC = 260;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        go_i = 1'b0, cont_i = 1'b0, stby_i = 1'b0, busy_i = 1'b0;
   logic [13:0] data_i = '0;
   logic        cnv_n_o, cs_n_o, rd_n_o, sleep_n_o, vld_o, err_nobusy_o, err_conv_o;
   logic [13:0] dat_o;

   adc_rdseq uut (
      .clk(clk), .rst_n(rst_n), .go_i(go_i), .cont_i(cont_i), .stby_i(stby_i),
      .busy_i(busy_i), .data_i(data_i), .cnv_n_o(cnv_n_o), .cs_n_o(cs_n_o),
      .rd_n_o(rd_n_o), .sleep_n_o(sleep_n_o), .vld_o(vld_o), .dat_o(dat_o),
      .err_nobusy_o(err_nobusy_o), .err_conv_o(err_conv_o)
   );

   always #4 clk = ~clk;

   int total = 0, bad = 0;
   bit done = 0;
   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // converter model
   int          mdl_mode = 0;   // 0 normal, 1 never busy, 2 busy stuck
   logic [13:0] word = 14'h0155;
   logic [13:0] exp_word = '0;
   int          busy_rise_cyc = 0;
   initial begin : model
      bit m_cnv_prev = 1, m_rd_prev = 1, m_arm = 0, m_run = 0;
      int m_dly = 0, m_len = 0;
      forever begin
         @(negedge clk);
         if (!m_cnv_prev && cnv_n_o && mdl_mode != 1) begin m_arm = 1; m_dly = BUSY_DLY; end
         m_cnv_prev = cnv_n_o;
         if (m_arm) begin
            if (m_dly == 0) begin
               busy_i = 1; busy_rise_cyc = cyc; m_arm = 0; m_run = 1; m_len = CONV_CYC;
            end else m_dly--;
         end else if (m_run && mdl_mode != 2) begin
            if (m_len == 0) begin
               busy_i = 0; data_i = word; exp_word = word; m_run = 0;
               word = word + 14'h0ABC;
            end else m_len--;
         end
         if (!m_rd_prev && rd_n_o) data_i = ~exp_word;
         m_rd_prev = rd_n_o;
      end
   end

   // monitor
   int n_cnv = 0, n_rd = 0, n_vld = 0, n_enb = 0, n_ecv = 0;
   int cnv_fall_cyc = 0, cnv_rise_cyc = 0, cnv_lo = 0;
   int rd_fall_cyc = 0, rd_rise_cyc = 0, rd_lo_min = 1000, rd_early = 0, cs_bad = 0;
   int gap_min = 100000, vld_wide = 0, enb_cyc = 0, ecv_cyc = 0;
   logic [13:0] vld_dat = '0;
   bit rd_seen = 0;
   initial begin : monitor
      bit pc = 1, pr = 1, pv = 0;
      forever begin
         @(negedge clk);
         if (pc && !cnv_n_o) begin
            n_cnv++; cnv_fall_cyc = cyc;
            if (rd_seen && (cyc - rd_rise_cyc) < gap_min) gap_min = cyc - rd_rise_cyc;
            rd_seen = 0;
         end
         if (!pc && cnv_n_o) begin cnv_rise_cyc = cyc; cnv_lo = cyc - cnv_fall_cyc; end
         if (pr && !rd_n_o) begin n_rd++; rd_fall_cyc = cyc; if (busy_i) rd_early++; end
         if (!pr && rd_n_o) begin
            rd_rise_cyc = cyc; rd_seen = 1;
            if (cyc - rd_fall_cyc < rd_lo_min) rd_lo_min = cyc - rd_fall_cyc;
         end
         if (!rd_n_o && cs_n_o) cs_bad++;
         if (vld_o) begin
            if (pv) vld_wide++;
            n_vld++; vld_dat = dat_o;
         end
         if (err_nobusy_o) begin n_enb++; enb_cyc = cyc; end
         if (err_conv_o) begin n_ecv++; ecv_cyc = cyc; end
         pc = cnv_n_o; pr = rd_n_o; pv = vld_o;
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic request_one();
      go_i = 1;
      while (cnv_n_o) @(negedge clk);
      go_i = 0;
   endtask

   task automatic t_reset();
      check(cnv_n_o && cs_n_o && rd_n_o && sleep_n_o, "R1 strobes idle high", {cnv_n_o, cs_n_o, rd_n_o, sleep_n_o}, 15);
      check(!vld_o && !err_nobusy_o && !err_conv_o, "R1 flags low", {vld_o, err_nobusy_o, err_conv_o}, 0);
   endtask

   task automatic t_single();
      int c0, v0;
      c0 = n_cnv; v0 = n_vld;
      request_one();
      while (!busy_i) @(negedge clk);
      idle(20);
      go_i = 1; @(negedge clk); go_i = 0;   // R9 stray request mid-conversion
      while (!vld_o) @(negedge clk);
      idle(1);
      check(cnv_lo == E_START, "R2 start strobe width", cnv_lo, E_START);
      check(vld_dat == exp_word, "R6 captured word", vld_dat, exp_word);
      check(n_vld == v0 + 1 && vld_wide == 0, "R6 single valid pulse", n_vld - v0, 1);
      check(rd_lo_min >= E_RD, "R5 read strobe width", rd_lo_min, E_RD);
      check(cs_bad == 0 && rd_early == 0, "R5 cs cover and read after busy", cs_bad + rd_early, 0);
      idle(300);
      check(n_cnv == c0 + 1, "R9 stray go ignored", n_cnv - c0, 1);
   endtask

   task automatic t_cont();
      int v0;
      logic [13:0] w;
      v0 = n_vld; gap_min = 100000;
      cont_i = 1;
      for (int k = 0; k < 3; k++) begin
         while (!vld_o) @(negedge clk);
         w = exp_word;
         idle(1);
         check(vld_dat == w, "R10 continuous word", vld_dat, w);
      end
      cont_i = 0;
      idle(450);
      check(n_vld - v0 >= 3, "R10 repeated conversions", n_vld - v0, 3);
      check(gap_min >= E_GAP, "R7 release plus acquisition spacing", gap_min, E_GAP);
   endtask

   task automatic t_nobusy();
      int r0, e0;
      r0 = n_rd; e0 = n_enb;
      mdl_mode = 1;
      request_one();
      while (!err_nobusy_o) @(negedge clk);
      idle(1);
      check(enb_cyc - cnv_rise_cyc == E_BHI, "R3 busy-rise timeout delay", enb_cyc - cnv_rise_cyc, E_BHI);
      idle(100);
      check(n_enb == e0 + 1 && n_rd == r0, "R3 one error, no read", n_rd - r0, 0);
      mdl_mode = 0;
   endtask

   task automatic t_stuck();
      int r0, d;
      r0 = n_rd;
      mdl_mode = 2;
      request_one();
      while (!err_conv_o) @(negedge clk);
      idle(1);
      d = ecv_cyc - busy_rise_cyc;
      check(d >= E_CONV && d <= E_CONV + 4, "R4 conversion timeout delay", d, E_CONV);
      check(n_rd == r0, "R4 no read after timeout", n_rd - r0, 0);
      mdl_mode = 0;
      idle(400);
   endtask

   task automatic t_stby_go();
      int c0, rel;
      c0 = n_cnv;
      stby_i = 1; go_i = 1;
      idle(2);
      check(!sleep_n_o, "R8 sleep output follows request", sleep_n_o, 0);
      idle(100);
      check(n_cnv == c0, "R8 no start during standby", n_cnv - c0, 0);
      stby_i = 0; rel = cyc;
      while (cnv_n_o) @(negedge clk);
      go_i = 0;
      idle(1);
      check(cnv_fall_cyc - rel >= E_WAKE, "R8 wake-up interval", cnv_fall_cyc - rel, E_WAKE);
      check(sleep_n_o, "R8 sleep released", sleep_n_o, 1);
      while (!vld_o) @(negedge clk);
      idle(1);
      check(vld_dat == exp_word, "R6 word after wake", vld_dat, exp_word);
      idle(300);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      idle(3);
      t_reset();
      rst_n = 1;
      idle(3);
      t_reset();
      t_single();
      t_cont();
      t_nobusy();
      t_stuck();
      t_stby_go();
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule